// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer controlled through four 32-bit register slots on a simple valid/write/address/data port. Software programs a mode word (enable, output selection, reset pulse length) and a counter-control word (reload value, prescaler choice), then must keep writing a fixed restart word before the counter drains. If it fails to do so, the block flags the expiry in a read-only status bit and raises an interrupt level, a timed reset pulse, or both.

Every configuration write is guarded: the mode and counter-control words carry a key in their upper bits, and a write whose key does not match is dropped without trace. The restart slot accepts one exact 32-bit value only. The counter is loaded with the reload field placed above a run of ones, so the smallest setting still gives a long window, and it decrements once per prescaler period while enabled.

Top module: `keyed_watchdog`

## Requirements
- R1: A write to slot 0x0 is accepted only when bits [23:12] equal 0xABC; it then sets run (bit 0), reset-output enable (bit 1), interrupt enable (bit 2) and pulse-length code (bits [5:4]). Reading slot 0x0 returns those fields in the same positions with every other bit, the key included, read as zero.
- R2: A write to slot 0x4 is accepted only when bits [23:14] equal 0x248 (the word pattern 0x00920000); it then sets the 12-bit reload value (bits [13:2]) and prescaler select (bits [1:0]). Reading slot 0x4 returns reload and select in those positions, all other bits zero.
- R3: Writing exactly 0x00001999 to slot 0x8 loads the counter with the reload value times 4096 plus 4095, restarts the prescaler and clears the status bit; any other value written there changes nothing, and a restart before expiry prevents it.
- R4: The prescaler divides by 8, 64, 512 or 4096 for select 0, 1, 2, 3; the counter decrements once per prescaler period only while run is set, and holds its value while run is clear.
- R5: When the counter decrements to zero, status bit 0 (read at slot 0xC) is set and stays set until a valid restart; with reload 0 and select 0 this happens 32760 cycles after the restart write is taken.
- R6: irq_o is high exactly while the status bit is set and interrupt enable is set.
- R7: On expiry with reset-output enable set, rst_pulse_o is high for 2, 4, 8 or 16 cycles for pulse-length code 0, 1, 2, 3; it stays low while reset-output enable is clear.
- R8: After reset all fields, the counter and the status are zero, both outputs are low and every slot reads zero.
- R9: Writes to slot 0xC are ignored and slot 0x8 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per write |
| bus_write | input | 1 | High for a write access |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] pick the slot |
| bus_wdata | input | 32 | Write data including key field |
| bus_rdata | output | 32 | Read data for the slot on bus_addr, combinational |
| irq_o | output | 1 | Interrupt level on expiry |
| rst_pulse_o | output | 1 | Timed reset pulse on expiry |

## Verification
The assertions assume that a write is a single-cycle strobe of bus_valid with bus_write and that address and data are stable while it is high; they also assume reset is applied before any access. The stimulus drives every access for exactly one clock from the falling edge and returns the strobe low afterwards. Random words hit the mode and counter-control slots before the counter has ever been loaded, so no expiry interferes with the key checks, and the long timing windows are then exercised with directed restart, disable and pulse scenarios.

// File: rtl/keyed_wdg_pkg.sv
package keyed_wdg_pkg;
   localparam logic [11:0] MODE_KEY  = 12'hABC;
   localparam logic [9:0]  CTRL_KEY  = 10'h248;
   localparam logic [31:0] KICK_WORD = 32'h0000_1999;

   localparam logic [1:0] SLOT_MODE = 2'd0;
   localparam logic [1:0] SLOT_CTRL = 2'd1;
   localparam logic [1:0] SLOT_KICK = 2'd2;
   localparam logic [1:0] SLOT_STAT = 2'd3;

   typedef struct packed {
      logic [1:0] plen;
      logic       irq_en;
      logic       rst_en;
      logic       run;
   } mode_t;
endpackage

// File: rtl/keyed_wdg_regs.sv
module keyed_wdg_regs
   import keyed_wdg_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int RELOAD_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_stb,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [31:0]         wdata,
   output mode_t               mode_q,
   output logic [RELOAD_W-1:0] reload_q,
   output logic [1:0]          psel_q,
   output logic                kick
);
   logic [1:0] slot;
   logic       mode_hit;
   logic       ctrl_hit;

   assign slot     = addr[3:2];
   assign mode_hit = wr_stb && (slot == SLOT_MODE) && (wdata[23:12] == MODE_KEY);
   assign ctrl_hit = wr_stb && (slot == SLOT_CTRL) && (wdata[23:14] == CTRL_KEY);
   assign kick     = wr_stb && (slot == SLOT_KICK) && (wdata == KICK_WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (mode_hit) begin
         mode_q.run    <= wdata[0];
         mode_q.rst_en <= wdata[1];
         mode_q.irq_en <= wdata[2];
         mode_q.plen   <= wdata[5:4];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         psel_q   <= '0;
      end else if (ctrl_hit) begin
         reload_q <= wdata[2 +: RELOAD_W];
         psel_q   <= wdata[1:0];
      end
   end

   logic unused_bits;
   assign unused_bits = ^{addr};
endmodule

// File: rtl/keyed_wdg_prescaler.sv
module keyed_wdg_prescaler #(
   parameter int STEP_LOG = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       clr,
   input  logic [1:0] psel,
   output logic       tick
);
   localparam int SEL_N = 4;
   localparam int PRE_W = STEP_LOG * SEL_N;

   logic [PRE_W-1:0] pcnt_q;
   logic [PRE_W-1:0] term [SEL_N];

   for (genvar s = 0; s < SEL_N; s++) begin : g_term
      assign term[s] = PRE_W'((64'd1 << (STEP_LOG * (s + 1))) - 64'd1);
   end

   assign tick = run && (pcnt_q >= term[psel]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
      end else if (clr || !run || tick) begin
         pcnt_q <= '0;
      end else begin
         pcnt_q <= pcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/keyed_wdg_core.sv
module keyed_wdg_core #(
   parameter int RELOAD_W = 12,
   parameter int LOW_W    = 12,
   parameter int PLEN_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                kick,
   input  logic [RELOAD_W-1:0] reload,
   input  logic [PLEN_W-1:0]   plen,
   input  logic                rst_en,
   output logic                expired_o,
   output logic                pulse_o
);
   localparam int CNT_W  = RELOAD_W + LOW_W;
   localparam int LEN_N  = 1 << PLEN_W;
   localparam int PLS_W  = LEN_N + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [PLS_W-1:0] pls_q;
   logic [PLS_W-1:0] len_tab [LEN_N];
   logic             hit_zero;

   for (genvar p = 0; p < LEN_N; p++) begin : g_len
      assign len_tab[p] = PLS_W'(1) << (p + 1);
   end

   assign hit_zero = tick && !kick && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (kick) begin
         cnt_q <= {reload, {LOW_W{1'b1}}};
      end else if (tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expired_o <= 1'b0;
      end else if (kick) begin
         expired_o <= 1'b0;
      end else if (hit_zero) begin
         expired_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pls_q <= '0;
      end else if (hit_zero && rst_en) begin
         pls_q <= len_tab[plen];
      end else if (pls_q != '0) begin
         pls_q <= pls_q - 1'b1;
      end
   end

   assign pulse_o = (pls_q != '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import keyed_wdg_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int LOW_W    = 12,
   parameter int STEP_LOG = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_o,
   output logic              rst_pulse_o
);
   localparam int RELOAD_W = 12;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("keyed_watchdog: ADDR_W must be at least 4");
   end
   if (LOW_W < 1 || LOW_W > 20) begin : g_bad_low
      $error("keyed_watchdog: LOW_W out of range");
   end
   if (STEP_LOG < 1 || STEP_LOG > 4) begin : g_bad_step
      $error("keyed_watchdog: STEP_LOG out of range");
   end

   mode_t               mode_q;
   logic [RELOAD_W-1:0] reload_q;
   logic [1:0]          psel_q;
   logic                kick;
   logic                tick;
   logic                expired_w;

   keyed_wdg_regs #(.ADDR_W(ADDR_W), .RELOAD_W(RELOAD_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (bus_valid && bus_write),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .mode_q   (mode_q),
      .reload_q (reload_q),
      .psel_q   (psel_q),
      .kick     (kick)
   );

   keyed_wdg_prescaler #(.STEP_LOG(STEP_LOG)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (mode_q.run),
      .clr   (kick),
      .psel  (psel_q),
      .tick  (tick)
   );

   keyed_wdg_core #(.RELOAD_W(RELOAD_W), .LOW_W(LOW_W), .PLEN_W(2)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .kick      (kick),
      .reload    (reload_q),
      .plen      (mode_q.plen),
      .rst_en    (mode_q.rst_en),
      .expired_o (expired_w),
      .pulse_o   (rst_pulse_o)
   );

   assign irq_o = expired_w && mode_q.irq_en;

   always_comb begin
      case (bus_addr[3:2])
         SLOT_MODE: bus_rdata = {26'b0, mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.run};
         SLOT_CTRL: bus_rdata = 32'({reload_q, psel_q});
         SLOT_STAT: bus_rdata = {31'b0, expired_w};
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/keyed_wdg_checker.sv
module keyed_wdg_checker #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq_o,
   input logic              rst_pulse_o,
   input logic [4:0]        mode_bits,
   input logic              expired
);
   logic wr_mode_bad;
   logic wr_kick_ok;

   assign wr_mode_bad = bus_valid && bus_write && (bus_addr[3:2] == 2'd0)
                        && (bus_wdata[23:12] != 12'hABC);
   assign wr_kick_ok  = bus_valid && bus_write && (bus_addr[3:2] == 2'd2)
                        && (bus_wdata == 32'h0000_1999);

   a_r1_mode_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mode_bad |=> $stable(mode_bits));

   a_r3_kick_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
      wr_kick_ok |=> !expired);

   a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !wr_kick_ok) |=> expired);

   a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> expired);

   a_r7_pulse_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_pulse_o) |-> $rose(expired));
endmodule

bind keyed_watchdog keyed_wdg_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_valid   (bus_valid),
   .bus_write   (bus_write),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .irq_o       (irq_o),
   .rst_pulse_o (rst_pulse_o),
   .mode_bits   (mode_q),
   .expired     (expired_w)
);

// File: tb/keyed_watchdog_tb.sv
`timescale 1ns/1ps
module keyed_watchdog_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic        rst_pulse_o;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   keyed_watchdog u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_valid   (bus_valid),
      .bus_write   (bus_write),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .irq_o       (irq_o),
      .rst_pulse_o (rst_pulse_o)
   );

   localparam int EXPIRE_CYC = 8 * 4095;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] mode_word(input logic [5:0] f);
      return {26'b0, f[5:4], 1'b0, f[2:0]};
   endfunction

   task automatic expect_status(input logic exp, input string req);
      logic [31:0] r;
      bus_rd(4'hC, r);
      check(r == {31'b0, exp}, req, r, {31'b0, exp});
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [31:0] d;
      logic [31:0] exp_mode;
      logic [31:0] exp_ctrl;
      int n;
      int w;
      bit pulse_seen;
      void'($urandom(32'h5eed_1234));

      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: reset state
      check(irq_o == 1'b0, "R8 irq", {31'b0, irq_o}, 0);
      check(rst_pulse_o == 1'b0, "R8 pulse", {31'b0, rst_pulse_o}, 0);
      for (int a = 0; a < 16; a += 4) begin
         bus_rd(a[3:0], r);
         check(r == 0, "R8 read", r, 0);
      end

      // R1: random mode writes, half with the correct key
      exp_mode = 0;
      for (int i = 0; i < 30; i++) begin
         d = $urandom;
         if ($urandom % 2) d[23:12] = 12'hABC;
         bus_wr(4'h0, d);
         if (d[23:12] == 12'hABC) exp_mode = mode_word(d[5:0]);
         bus_rd(4'h0, r);
         check(r == exp_mode, "R1 mode readback", r, exp_mode);
      end

      // R2: random counter-control writes
      exp_ctrl = 0;
      for (int i = 0; i < 30; i++) begin
         d = $urandom;
         if ($urandom % 2) d[23:14] = 10'h248;
         bus_wr(4'h4, d);
         if (d[23:14] == 10'h248) exp_ctrl = {18'b0, d[13:0]};
         bus_rd(4'h4, r);
         check(r == exp_ctrl, "R2 ctrl readback", r, exp_ctrl);
      end

      // R9: restart slot reads zero
      bus_rd(4'h8, r);
      check(r == 0, "R9 restart read", r, 0);

      // Test A: R5 timing with reload 0, select 0, interrupt output
      bus_wr(4'h0, 32'h00AB_C005);
      bus_wr(4'h4, 32'h0092_0000);
      bus_wr(4'h8, 32'h0000_1999);
      n = 0; pulse_seen = 0;
      while (!irq_o && n < 40000) begin
         @(negedge clk);
         n++;
         if (rst_pulse_o) pulse_seen = 1;
      end
      check(n == EXPIRE_CYC, "R5 expiry time", n, EXPIRE_CYC);
      check(!pulse_seen, "R7 no pulse when disabled", {31'b0, pulse_seen}, 0);
      expect_status(1'b1, "R5 status set");

      // R3: wrong restart value has no effect
      bus_wr(4'h8, 32'h0000_1998);
      expect_status(1'b1, "R3 bad kick ignored");
      bus_wr(4'h8, 32'h0100_1999);
      expect_status(1'b1, "R3 bad kick high bits");
      // R9: status write ignored
      bus_wr(4'hC, 32'h0000_0000);
      expect_status(1'b1, "R9 status write ignored");
      // R6: interrupt follows enable
      bus_wr(4'h0, 32'h00AB_C001);
      check(irq_o == 1'b0, "R6 irq masked", {31'b0, irq_o}, 0);
      bus_wr(4'h0, 32'h00AB_C005);
      check(irq_o == 1'b1, "R6 irq unmasked", {31'b0, irq_o}, 1);
      // R3: valid restart clears
      bus_wr(4'h8, 32'h0000_1999);
      expect_status(1'b0, "R3 kick clears status");
      check(irq_o == 1'b0, "R6 irq low after kick", {31'b0, irq_o}, 0);

      // Test B: R4 counter holds while disabled
      wait_cyc(16000);
      bus_wr(4'h0, 32'h00AB_C004);
      wait_cyc(8000);
      bus_wr(4'h0, 32'h00AB_C005);
      wait_cyc(16000);
      expect_status(1'b0, "R4 hold while disabled");
      wait_cyc(1500);
      expect_status(1'b1, "R4 resumes after enable");

      // Test C: R3 restart before expiry prevents it
      bus_wr(4'h8, 32'h0000_1999);
      wait_cyc(17000);
      bus_wr(4'h8, 32'h0000_1999);
      wait_cyc(17000);
      expect_status(1'b0, "R3 mid restart");

      // Test D: R7 reset pulse, code 2 gives 8 cycles, interrupt off
      bus_wr(4'h0, 32'h00AB_C023);
      bus_wr(4'h8, 32'h0000_1999);
      n = 0;
      while (!rst_pulse_o && n < 40000) begin
         @(negedge clk);
         n++;
      end
      check(n == EXPIRE_CYC, "R7 pulse start time", n, EXPIRE_CYC);
      w = 0;
      while (rst_pulse_o && w < 100) begin
         @(negedge clk);
         w++;
      end
      check(w == 8, "R7 pulse width", w, 8);
      check(irq_o == 1'b0, "R6 irq off when disabled", {31'b0, irq_o}, 0);
      expect_status(1'b1, "R5 status after pulse");

      // Test E: R4 select 1 divides by 64, so no expiry in the divide-by-8 window
      bus_wr(4'h4, 32'h0092_0001);
      bus_wr(4'h0, 32'h00AB_C005);
      bus_wr(4'h8, 32'h0000_1999);
      wait_cyc(34000);
      expect_status(1'b0, "R4 slower prescaler");
      check(irq_o == 1'b0, "R6 irq idle", {31'b0, irq_o}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule